// File: doc/BRIEF.md
# Programmable Free-Running Clock Output Generator

This block makes two free-running clocks for an external pin from a core clock that runs at twice the bus rate. One bus cycle is two core cycles. The first output is the bus clock divided by a programmable ratio from 1 to 32. An optional divide-by-16 stage can follow the ratio. The second output runs at the core rate, which is twice the bus rate. It is formed by gating the core clock with an enable that changes only while the core clock is low.

An 8-bit control register sets both outputs. It is written through a single-cycle strobe and can be read back at any time. Each output has its own disable bit. The divided output picks up a new setting only at the end of its current period, so reprogramming never shortens a high or low phase.

Top module: `free_clock_out`

## Requirements
- R1: While reset is held, and after it is released, the register reads 0xC0 and both clock outputs stay low until software enables them.
- R2: A write with the strobe high stores the write data on that core edge, and the read port returns the stored byte exactly from the next cycle on.
- R3: Register bits 4:0 hold a ratio value N. With bit 5 clear, the divided output has a period of N+1 bus cycles, which is 2(N+1) core cycles.
- R4: Register bit 5, when set, multiplies the divisor by 16. The period becomes 16(N+1) bus cycles.
- R5: Let D be the total divisor. If D is even, the high and low phases are each D core cycles. If D is odd and above 1, the high phase lasts D-1 core cycles and the low phase D+1, so the high phase is one bus cycle shorter. If D is 1, the output is high for one core cycle and low for the next.
- R6: Register bit 7 set holds the divided output at 0. Setting it during a high phase lets that phase finish at its full length, and the output then stays low.
- R7: Register bit 6 clear makes the second output follow the core clock. It is high while the core clock is high and low while the core clock is low. Bit 6 set holds it at 0.
- R8: A change to the ratio or to the prescaler bit takes effect only at the end of the running period. A high phase that is in progress keeps its programmed length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| div_clk | output | 1 | Divided free-running clock |
| dbl_clk | output | 1 | Clock at twice the bus rate |

## Verification
The assertions check four things on every core cycle:
- the read-back port,
- that the divided output changes only at a period start or at the programmed high/low boundary (no runt pulses),
- that a period starting with the disable bit set begins low,
- that the period counter stays in range.

Only the bench scenarios can show the remaining behaviour:
- the measured high and low lengths for each divisor, with and without the prescaler,
- the deferred pick-up of a new setting or a disable during a running high phase,
- the shape of the doubled clock within a core cycle.

// File: rtl/free_clock_out.sv
module free_clock_out #(
  parameter int          RATIO_W   = 5,
  parameter int          PRE_SHIFT = 4,
  parameter logic [7:0]  RST_VAL   = 8'hC0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       div_clk,
  output logic       dbl_clk
);

  localparam int DMAX = (2 ** RATIO_W) << PRE_SHIFT;
  localparam int CW   = $clog2(2 * DMAX);

  logic [7:0]    ctrl_q;
  logic [CW-1:0] cnt_q, last_q, hi_q;
  logic          en_q, out_q, dbl_en_q;

  assign rdata = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= RST_VAL;
    else if (wr_en) ctrl_q <= wdata;
  end

  logic [CW-1:0] base, d_new, last_new, hi_new;
  assign base     = CW'(ctrl_q[RATIO_W-1:0]) + CW'(1);
  assign d_new    = ctrl_q[5] ? (base << PRE_SHIFT) : base;
  assign last_new = (d_new << 1) - CW'(1);
  assign hi_new   = (d_new == CW'(1)) ? CW'(1) : (d_new & ~CW'(1));

  logic          wrap, en_n;
  logic [CW-1:0] cnt_n, last_n, hi_n;
  assign wrap   = (cnt_q == last_q);
  assign cnt_n  = wrap ? '0 : cnt_q + CW'(1);
  assign en_n   = wrap ? ~ctrl_q[7] : en_q;
  assign last_n = wrap ? last_new : last_q;
  assign hi_n   = wrap ? hi_new : hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= CW'(1);
      hi_q   <= CW'(1);
      en_q   <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      last_q <= last_n;
      hi_q   <= hi_n;
      en_q   <= en_n;
      out_q  <= en_n && (cnt_n < hi_n);
    end
  end

  assign div_clk = out_q;

  always_ff @(negedge clk) begin
    if (rst) dbl_en_q <= 1'b0;
    else     dbl_en_q <= ~ctrl_q[6];
  end

  assign dbl_clk = clk & dbl_en_q;

  assert_rd_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> rdata == $past(wdata));

  assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && $past(ctrl_q[7])) |-> !div_clk);

  assert_no_runt_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_clk) |-> (cnt_q == '0 || cnt_q == hi_q));

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_q);

endmodule

// File: tb/test_free_clock_out.sv
module test_free_clock_out;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic div_clk, dbl_clk;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  free_clock_out i_free_clock_out (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .div_clk(div_clk), .dbl_clk(dbl_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
    check("R2", rdata, v);
  endtask

  task automatic settle();
    repeat (1100) @(negedge clk);
  endtask

  // driver: push the expected high and low lengths in core cycles
  task automatic drive_cfg(input logic [7:0] v);
    int d, h;
    wr(v);
    d = (int'(v[4:0]) + 1) * (v[5] ? 16 : 1);
    h = (d == 1) ? 1 : 2 * (d / 2);
    exp_q.push_back(h);
    exp_q.push_back(2 * d - h);
    settle();
  endtask

  // monitor: measure one full period and compare it with the queue
  task automatic monitor(input string req);
    int h = 0, l = 0, g = 0;
    int eh, el;
    @(negedge clk);
    while (div_clk && g < 3000) begin @(negedge clk); g++; end
    while (!div_clk && g < 3000) begin @(negedge clk); g++; end
    while (div_clk && g < 3000) begin h++; @(negedge clk); g++; end
    while (!div_clk && g < 3000) begin l++; @(negedge clk); g++; end
    eh = exp_q.pop_front();
    el = exp_q.pop_front();
    check({req, " high"}, h, eh);
    check({req, " low"}, l, el);
  endtask

  initial begin
    int hits;
    int h;
    repeat (4) @(negedge clk);
    check("R1", rdata, 8'hC0);
    check("R1", div_clk, 0);
    rst = 1'b0;
    hits = 0;
    repeat (200) begin @(negedge clk); hits += int'(div_clk); end
    check("R1", hits, 0);
    check("R1", rdata, 8'hC0);

    drive_cfg(8'h00); monitor("R3 R5 div1");
    drive_cfg(8'h01); monitor("R3 div2");
    drive_cfg(8'h02); monitor("R5 div3");
    drive_cfg(8'h04); monitor("R5 div5");
    drive_cfg(8'h1F); monitor("R3 div32");
    drive_cfg(8'h20); monitor("R4 div16");
    drive_cfg(8'h21); monitor("R4 div32");
    drive_cfg(8'h22); monitor("R4 div48");
    drive_cfg(8'h3F); monitor("R4 div512");

    // R8: ratio change during a high phase keeps the phase length
    drive_cfg(8'h1F); monitor("R8 pre");
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);
    h = 1;
    wr_en = 1'b1; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    while (div_clk && h < 3000) begin h++; @(negedge clk); end
    check("R8 high kept", h, 32);
    exp_q.push_back(1); exp_q.push_back(1);
    monitor("R8 new");

    // R6: disable during a high phase, then held low
    drive_cfg(8'h1F); monitor("R6 pre");
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);
    h = 1;
    wr_en = 1'b1; wdata = 8'h9F;
    @(negedge clk); wr_en = 1'b0;
    while (div_clk && h < 3000) begin h++; @(negedge clk); end
    check("R6 high kept", h, 32);
    hits = 0;
    repeat (1100) begin @(negedge clk); hits += int'(div_clk); end
    check("R6 held low", hits, 0);
    check("R6 readback", rdata, 8'h9F);

    // R7: doubled clock follows core clock, then held low
    repeat (4) @(negedge clk);
    @(posedge clk); #1; check("R7 high phase", dbl_clk, 1);
    @(negedge clk); #1; check("R7 low phase", dbl_clk, 0);
    wr(8'hDF);
    hits = 0;
    repeat (50) begin
      @(posedge clk); #1; hits += int'(dbl_clk);
      @(negedge clk); #1; hits += int'(dbl_clk);
    end
    check("R7 disabled", hits, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule